// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is a slave on a two-wire I2C bus. It answers one fixed 7-bit device address, 1001111 binary. Through it an external host can read and write a 256-byte register space. It takes SCL as an input only and never stretches the clock. It samples SDA and can only pull SDA low; an external pull-up supplies the high level. Both bus lines pass through two-flop synchronizers and are edge-detected in the local clock domain, so the local clock must run at least eight times faster than SCL.

A write transaction works as follows. The address byte carries the direction bit in its last bit, and 0 there means write. The first byte after the address loads an 8-bit register pointer. Each later byte appears on a one-cycle parallel write strobe at the pointer, and the pointer then steps by one.

A read transaction starts by returning the byte at the current pointer, most significant bit first. Each acknowledge from the master steps the pointer and starts the next byte. A missing acknowledge makes the slave let go of the bus until the next start or stop. The register file sits outside the block, behind a combinational read port addressed by the pointer.

Top module: `i2c_reg_slave`

## Requirements
- R1: An address byte whose upper seven bits equal 1001111 is acknowledged by pulling SDA low during the ninth clock. Any other address gets no acknowledge, and the following bytes are neither acknowledged nor written, until the next start or stop.
- R2: A falling SDA edge while SCL is high (start) always returns the slave to receiving an address. A rising SDA edge while SCL is high (stop) always returns it to idle, where bytes without a preceding start are ignored.
- R3: In a write transaction, the first byte after the address loads the register pointer, which is visible on `reg_addr`, and the slave acknowledges that byte.
- R4: Each following write byte produces a single-cycle `reg_wr` pulse with the byte on `reg_wdata` at the current pointer, after which the pointer steps by one. Every such byte is acknowledged, including bytes aimed at unimplemented registers.
- R5: The pointer is 8 bits wide and wraps from 255 to 0, both for writes and for reads acknowledged by the master.
- R6: In a read transaction (direction bit 1), the slave sends the byte at the pointer MSB first. Each master acknowledge (SDA low on the ninth clock) steps the pointer and starts the next byte from the new pointer.
- R7: A master non-acknowledge (SDA high on the ninth clock) makes the slave release SDA. It drives nothing more until the next start or stop.
- R8: After reset, SDA is released, `reg_wr` is low and the pointer is 0.
- R9: Protocol recovery: from any state, clocking SCL with the master holding SDA high until SDA reads high, followed by a start, returns the slave to receiving its address.
- R10: The SDA pull-down enable changes only while the synchronized SCL is low, so the slave's bit stays stable through each SCL high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr | output | 8 | Register pointer, address of the parallel port |
| reg_wdata | output | 8 | Byte to write |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Byte at `reg_addr`, read combinationally |

## Verification
A table of pointer/data pairs drives single-byte writes, each read back with a random read. This separates pointer loading from data transfer across varied bit patterns, including all-zero and all-one bytes. Multi-byte bursts are then run in both directions. Bursts that start at 255 tell a correct wrap apart from a pointer that saturates or grows to nine bits. Bursts at unimplemented addresses tell "received" apart from "stored".

Interrupted transfers test the recovery paths separately from normal traffic: a wrong device address, a repeated start in the middle of a byte, a stop followed by traffic with no start, and a master non-acknowledge followed by further clocks. A final case clocks out of a read in which the slave is holding SDA low and checks that a start is honoured afterwards.

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
  parameter logic [6:0] DEV_ID = 7'b1001111,
  parameter int         BITS   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe,
  output logic [BITS-1:0] reg_addr,
  output logic [BITS-1:0] reg_wdata,
  output logic            reg_wr,
  input  logic [BITS-1:0] reg_rdata
);
  localparam logic [3:0] S_IDLE = 4'd0, S_ADDR = 4'd1, S_AACK = 4'd2, S_PTR = 4'd3,
                         S_PACK = 4'd4, S_WR   = 4'd5, S_WACK = 4'd6, S_RD  = 4'd7,
                         S_MACK = 4'd8, S_SKIP = 4'd9;
  localparam logic [3:0] LAST = 4'(BITS);

  logic [2:0] scl_q, sda_q;
  logic [3:0] st, bitcnt;
  logic [BITS-1:0] sh, ptr;
  logic rnw, mack;

  wire scl_s = scl_q[1];
  wire scl_p = scl_q[2];
  wire sda_s = sda_q[1];
  wire sda_p = sda_q[2];
  wire scl_rise  = scl_s & ~scl_p;
  wire scl_fall  = ~scl_s & scl_p;
  wire bus_start = scl_s & scl_p & sda_p & ~sda_s;
  wire bus_stop  = scl_s & scl_p & ~sda_p & sda_s;

  assign reg_addr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      bitcnt    <= '0;
      sh        <= '0;
      ptr       <= '0;
      rnw       <= 1'b0;
      mack      <= 1'b0;
      sda_oe    <= 1'b0;
      reg_wr    <= 1'b0;
      reg_wdata <= '0;
    end else begin
      reg_wr <= 1'b0;
      if (reg_wr) ptr <= ptr + 1'b1;
      if (bus_start) begin
        st     <= S_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (bus_stop) begin
        st     <= S_IDLE;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_PTR, S_WR: begin
            if (scl_rise) begin
              sh     <= {sh[BITS-2:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == LAST) begin
              bitcnt <= '0;
              if (st == S_ADDR) begin
                if (sh[BITS-1:1] == DEV_ID) begin
                  rnw    <= sh[0];
                  sda_oe <= 1'b1;
                  st     <= S_AACK;
                end else begin
                  st <= S_SKIP;
                end
              end else if (st == S_PTR) begin
                ptr    <= sh;
                sda_oe <= 1'b1;
                st     <= S_PACK;
              end else begin
                reg_wdata <= sh;
                reg_wr    <= 1'b1;
                sda_oe    <= 1'b1;
                st        <= S_WACK;
              end
            end
          end
          S_AACK: begin
            if (scl_fall) begin
              if (rnw) begin
                sh     <= reg_rdata;
                sda_oe <= ~reg_rdata[BITS-1];
                st     <= S_RD;
              end else begin
                sda_oe <= 1'b0;
                st     <= S_PTR;
              end
            end
          end
          S_PACK, S_WACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              st     <= S_WR;
            end
          end
          S_RD: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == LAST) begin
                bitcnt <= '0;
                sda_oe <= 1'b0;
                st     <= S_MACK;
              end else begin
                sh     <= {sh[BITS-2:0], 1'b0};
                sda_oe <= ~sh[BITS-2];
              end
            end
          end
          S_MACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
              if (!sda_s) ptr <= ptr + 1'b1;
            end else if (scl_fall) begin
              if (mack) begin
                sh     <= reg_rdata;
                sda_oe <= ~reg_rdata[BITS-1];
                st     <= S_RD;
              end else begin
                st <= S_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_oe,
  input logic       reg_wr,
  input logic [7:0] reg_addr,
  input logic [3:0] st
);
  p_wr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  p_wr_in_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> st == 4'd6);

  p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> reg_addr == 8'($past(reg_addr) + 8'd1));

  p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_s));

  p_skip_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 4'd9) |-> (!sda_oe && !reg_wr));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 4'd0) |-> !sda_oe);
endmodule

bind i2c_reg_slave i2c_reg_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .st(st)
);

// File: tb/test_i2c_reg_slave.sv
module test_i2c_reg_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, reg_wr;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  wire sda_bus = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  i2c_reg_slave i_i2c_reg_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rdata(reg_rdata)
  );

  logic [7:0] mem [16];
  int wr_cnt;
  logic [7:0] last_wa, last_wd;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= 8'h00;
      wr_cnt  <= 0;
      last_wa <= 8'h00;
      last_wd <= 8'h00;
    end else if (reg_wr) begin
      wr_cnt  <= wr_cnt + 1;
      last_wa <= reg_addr;
      last_wd <= reg_wdata;
      if (reg_addr < 8'd16) mem[reg_addr[3:0]] <= reg_wdata;
    end
  end
  assign reg_rdata = (reg_addr < 8'd16) ? mem[reg_addr[3:0]] : 8'h00;

  int total = 0, bad = 0, unstable = 0;
  bit done = 0;
  logic [7:0] wbuf [4];
  logic [7:0] rbuf [4];

  localparam logic [15:0] VEC [6] = '{16'h003C, 16'h01A5, 16'h0FFF, 16'h0800, 16'h0A81, 16'h037E};

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cbit(input logic d, output logic s);
    logic s2;
    scl = 1'b0; tick(5); sda_m = d; tick(5);
    scl = 1'b1; tick(3); s = sda_bus; tick(6); s2 = sda_bus; tick(1);
    if (s != s2) unstable++;
  endtask

  task automatic start_c;
    scl = 1'b0; tick(5); sda_m = 1'b1; tick(5);
    scl = 1'b1; tick(10); sda_m = 1'b0; tick(10);
  endtask

  task automatic stop_c;
    scl = 1'b0; tick(5); sda_m = 1'b0; tick(5);
    scl = 1'b1; tick(10); sda_m = 1'b1; tick(10);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) cbit(b[i], s);
    cbit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    logic s;
    for (int i = 0; i < 8; i++) begin
      cbit(1'b1, s);
      d = {d[6:0], s};
    end
    cbit(~give_ack, s);
  endtask

  task automatic write_burst(input logic [7:0] p, input int n, input string rq);
    logic a;
    start_c;
    send_byte(8'h9E, a); chk(a, "R1 address ack", a, 1);
    send_byte(p, a);     chk(a, "R3 pointer ack", a, 1);
    chk(reg_addr == p, "R3 pointer loaded", reg_addr, p);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], a); chk(a, rq, a, 1);
    end
    stop_c;
  endtask

  task automatic read_burst(input logic [7:0] p, input int n, input bit do_stop);
    logic a;
    start_c;
    send_byte(8'h9E, a); chk(a, "R1 address ack", a, 1);
    send_byte(p, a);     chk(a, "R3 pointer ack", a, 1);
    start_c;
    send_byte(8'h9F, a); chk(a, "R6 read address ack", a, 1);
    for (int i = 0; i < n; i++) recv_byte(i < n - 1, rbuf[i]);
    if (do_stop) stop_c;
  endtask

  initial begin
    logic a, s;
    logic [7:0] d;
    int c0;
    tick(3);
    chk(sda_oe == 0 && reg_wr == 0 && reg_addr == 0, "R8 reset state", {sda_oe, reg_wr, reg_addr}, 0);
    rst_n = 1'b1;
    tick(5);
    chk(sda_oe == 0 && reg_addr == 0, "R8 after release", {sda_oe, reg_addr}, 0);

    for (int v = 0; v < 6; v++) begin
      wbuf[0] = VEC[v][7:0];
      write_burst(VEC[v][15:8], 1, "R4 single write ack");
      chk(last_wa == VEC[v][15:8] && last_wd == VEC[v][7:0], "R4 write port",
          {last_wa, last_wd}, VEC[v]);
      read_burst(VEC[v][15:8], 1, 1'b1);
      chk(rbuf[0] == VEC[v][7:0], "R6 random read", rbuf[0], VEC[v][7:0]);
    end

    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
    write_burst(8'h05, 3, "R4 burst ack");
    chk(mem[5] == 8'hA1 && mem[6] == 8'hB2 && mem[7] == 8'hC3, "R4 sequential write",
        {mem[5], mem[6], mem[7]}, 24'hA1B2C3);
    chk(reg_addr == 8'h08, "R4 pointer after burst", reg_addr, 8'h08);

    read_burst(8'h05, 3, 1'b1);
    chk(rbuf[0] == 8'hA1 && rbuf[1] == 8'hB2 && rbuf[2] == 8'hC3, "R6 sequential read",
        {rbuf[0], rbuf[1], rbuf[2]}, 24'hA1B2C3);
    chk(reg_addr == 8'h07, "R6 pointer after acked reads", reg_addr, 8'h07);

    c0 = wr_cnt;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    write_burst(8'h80, 2, "R4 unimplemented ack");
    chk(wr_cnt == c0 + 2 && reg_addr == 8'h82, "R4 unimplemented strobes", reg_addr, 8'h82);

    wbuf[0] = 8'h5A; wbuf[1] = 8'h6B;
    write_burst(8'hFF, 2, "R5 wrap write ack");
    chk(last_wa == 8'h00 && mem[0] == 8'h6B, "R5 write wrap", {last_wa, mem[0]}, 16'h006B);
    chk(reg_addr == 8'h01, "R5 pointer after wrap", reg_addr, 8'h01);

    read_burst(8'hFF, 2, 1'b1);
    chk(rbuf[0] == 8'h00 && rbuf[1] == 8'h6B, "R5 read wrap", {rbuf[0], rbuf[1]}, 16'h006B);

    c0 = wr_cnt;
    start_c;
    send_byte(8'h9C, a); chk(!a, "R1 wrong address nack", a, 0);
    send_byte(8'h00, a); chk(!a, "R1 ignored byte", a, 0);
    send_byte(8'h77, a); chk(!a, "R1 ignored byte", a, 0);
    stop_c;
    chk(wr_cnt == c0, "R1 no write after mismatch", wr_cnt, c0);

    read_burst(8'h05, 1, 1'b0);
    chk(rbuf[0] == 8'hA1, "R7 read before nack", rbuf[0], 8'hA1);
    c0 = 0;
    for (int i = 0; i < 9; i++) begin
      cbit(1'b1, s);
      if (!s) c0++;
    end
    chk(c0 == 0, "R7 released after nack", c0, 0);
    stop_c;

    send_byte(8'h9E, a); chk(!a, "R2 no start after stop", a, 0);

    start_c;
    send_byte(8'h9E, a);
    for (int i = 0; i < 3; i++) cbit(1'b0, s);
    start_c;
    send_byte(8'h9E, a); chk(a, "R2 repeated start mid byte", a, 1);
    send_byte(8'h02, a);
    send_byte(8'h44, a);
    stop_c;
    chk(mem[2] == 8'h44, "R2 write after restart", mem[2], 8'h44);

    start_c;
    send_byte(8'h9E, a);
    send_byte(8'h40, a);
    start_c;
    send_byte(8'h9F, a);
    for (int i = 0; i < 3; i++) cbit(1'b1, s);
    chk(!s, "R9 slave holding low", s, 0);
    for (int i = 0; i < 9; i++) cbit(1'b1, s);
    chk(s, "R9 sda high after clocks", s, 1);
    start_c;
    send_byte(8'h9E, a); chk(a, "R9 recovered address ack", a, 1);
    stop_c;

    chk(unstable == 0, "R10 sda stable while scl high", unstable, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule